// File: doc/BRIEF.md
# Multi-Node Shader Program Sequencer

This block walks a small shader program whose instructions sit in two separate stores: a texture-fetch store of up to 32 entries and an arithmetic store of up to 64 entries. The program is cut into one to four nodes. Within each node, every texture instruction is issued before any arithmetic instruction. The block turns a control word and four node descriptors into a stream of instruction addresses for each store, then signals completion.

A start pulse launches a run. The block raises one issue strobe at a time, either for the texture stream or for the arithmetic stream, together with the address. It holds that strobe and address until the matching ready input is high. After the last arithmetic instruction of the final node is accepted, `done` pulses for one cycle. Descriptors whose last-node flags are inconsistent are rejected with a one-cycle `desc_err` pulse, and no instruction is issued. The control inputs and descriptors must stay stable while `busy` is high.

Top module: `shader_node_seq`

## Requirements
- R1: `node_last` holds the node count minus one (0 means one node, 3 means four nodes). An N-node program uses descriptor slots 4−N up to 3 and runs them in ascending slot order, so the final node is always slot 3.
- R2: Each descriptor word is decoded as follows: arithmetic offset in bits [5:0], arithmetic end in bits [11:6], texture offset in bits [16:12], texture end in bits [21:17], last-node flag in bit 22.
- R3: Within a node, all texture issues come before all arithmetic issues. `tex_issue` and `alu_issue` are never high in the same cycle.
- R4: When `first_tex_en` is 0, the first node skips its texture phase. When it is 1, the first node runs its texture phase. Every later node always runs its texture phase.
- R5: The address issued for instruction i of a node's phase is master offset + node offset + i. It wraps modulo 32 on the texture stream and modulo 64 on the arithmetic stream.
- R6: A phase issues exactly end+1 instructions.
- R7: While a strobe is high and its ready input is low, the strobe stays high and the address stays unchanged on the next cycle.
- R8: `done` is high for exactly one cycle. That cycle is the one after the final arithmetic instruction of slot 3 is accepted. `busy` is low in that same cycle.
- R9: A start pulse while `busy` is high has no effect on the issued stream.
- R10: If bit 22 of slot 3 is clear, or bit 22 of any of slots 0 to 2 is set, a start pulse causes `desc_err` to go high for one cycle on the next cycle. In that case no instruction is issued and `busy` stays low.
- R11: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse; ignored while busy |
| node_last | input | 2 | Node count minus one |
| first_tex_en | input | 1 | First node has a texture phase |
| alu_base | input | 6 | Master offset into the arithmetic store |
| tex_base | input | 5 | Master offset into the texture store |
| node_desc | input | 4x23 | Descriptor slots 0..3 (slot k at bits [23k+22:23k]) |
| tex_ready | input | 1 | Texture stream accepts the current address |
| alu_ready | input | 1 | Arithmetic stream accepts the current address |
| tex_issue | output | 1 | Texture address valid |
| tex_addr | output | 5 | Texture instruction address |
| alu_issue | output | 1 | Arithmetic address valid |
| alu_addr | output | 6 | Arithmetic instruction address |
| busy | output | 1 | Program run in progress |
| done | output | 1 | One-cycle end-of-program pulse |
| desc_err | output | 1 | One-cycle descriptor consistency error |

## Verification
The tests use these programs:
- A one-node program with no texture phase, which isolates slot 3 and the texture skip.
- A four-node program whose master and node offsets push both streams past their wrap points, which separates modulo addressing from plain addition.
- Two-node programs with the texture phase first enabled, then disabled, under random ready stalls and stray start pulses. These tell holding apart from advancing, and show that a restart mid-run is ignored.
- Two descriptor sets, one missing the final flag and one with a flag on an early slot, which exercise the two error conditions.

// File: rtl/shader_seq_pkg.sv
package shader_seq_pkg;
  localparam int TEX_AW     = 5;
  localparam int ALU_AW     = 6;
  localparam int SLOTS      = 4;
  localparam int SLOT_W     = $clog2(SLOTS);
  localparam int DESC_W     = 1 + 2*TEX_AW + 2*ALU_AW;

  typedef enum logic [1:0] {SQ_IDLE, SQ_TEX, SQ_ALU} seq_state_e;

  // packed from MSB: flag[22], tex end[21:17], tex off[16:12], alu end[11:6], alu off[5:0]
  typedef struct packed {
    logic              fin;
    logic [TEX_AW-1:0] tex_end;
    logic [TEX_AW-1:0] tex_off;
    logic [ALU_AW-1:0] alu_end;
    logic [ALU_AW-1:0] alu_off;
  } node_desc_t;

  function automatic logic [SLOT_W-1:0] first_slot_f(input logic [SLOT_W-1:0] last_idx);
    return SLOT_W'(SLOTS - 1) - last_idx;
  endfunction
endpackage

// File: rtl/seq_flag_check.sv
module seq_flag_check
  import shader_seq_pkg::*;
(
  input  node_desc_t slot_d [SLOTS],
  output logic       bad
);
  logic [SLOTS-1:0] wrong;
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s == SLOTS - 1) begin : g_final
      assign wrong[s] = !slot_d[s].fin;
    end else begin : g_early
      assign wrong[s] = slot_d[s].fin;
    end
  end
  assign bad = |wrong;
endmodule

// File: rtl/seq_addr_sum.sv
module seq_addr_sum #(
  parameter int W = 6
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] off,
  input  logic [W-1:0] idx,
  output logic [W-1:0] addr
);
  assign addr = base + off + idx;
endmodule

// File: rtl/shader_node_seq.sv
module shader_node_seq
  import shader_seq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [1:0]                    node_last,
  input  logic                          first_tex_en,
  input  logic [5:0]                    alu_base,
  input  logic [4:0]                    tex_base,
  input  logic [3:0][22:0]              node_desc,
  input  logic                          tex_ready,
  input  logic                          alu_ready,
  output logic                          tex_issue,
  output logic [4:0]                    tex_addr,
  output logic                          alu_issue,
  output logic [5:0]                    alu_addr,
  output logic                          busy,
  output logic                          done,
  output logic                          desc_err
);
  seq_state_e        state;
  logic [SLOT_W-1:0] slot;
  logic [ALU_AW-1:0] idx;
  logic              done_q, err_q;
  node_desc_t        slot_d [SLOTS];
  node_desc_t        cur;
  logic              flags_bad;

  for (genvar s = 0; s < SLOTS; s++) begin : g_unpack
    assign slot_d[s] = node_desc_t'(node_desc[s]);
  end

  seq_flag_check u_flags (.slot_d(slot_d), .bad(flags_bad));

  assign cur = slot_d[slot];

  // named events for the checker
  logic tex_fire, alu_fire, tex_last, alu_last, final_slot, start_ok, start_bad;
  assign tex_fire   = (state == SQ_TEX) && tex_ready;
  assign alu_fire   = (state == SQ_ALU) && alu_ready;
  assign tex_last   = idx[TEX_AW-1:0] == cur.tex_end;
  assign alu_last   = idx == cur.alu_end;
  assign final_slot = slot == SLOT_W'(SLOTS - 1);
  assign start_ok   = (state == SQ_IDLE) && start && !flags_bad;
  assign start_bad  = (state == SQ_IDLE) && start && flags_bad;

  seq_addr_sum #(.W(TEX_AW)) u_tex_sum (
    .base(tex_base), .off(cur.tex_off), .idx(idx[TEX_AW-1:0]), .addr(tex_addr));
  seq_addr_sum #(.W(ALU_AW)) u_alu_sum (
    .base(alu_base), .off(cur.alu_off), .idx(idx), .addr(alu_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      slot   <= '0;
      idx    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= alu_fire && alu_last && final_slot;
      err_q  <= start_bad;
      unique case (state)
        SQ_IDLE: if (start_ok) begin
          slot  <= first_slot_f(node_last);
          idx   <= '0;
          state <= first_tex_en ? SQ_TEX : SQ_ALU;
        end
        SQ_TEX: if (tex_fire) begin
          if (tex_last) begin
            state <= SQ_ALU;
            idx   <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SQ_ALU: if (alu_fire) begin
          if (alu_last) begin
            idx <= '0;
            if (final_slot) begin
              state <= SQ_IDLE;
            end else begin
              slot  <= slot + 1'b1;
              state <= SQ_TEX;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign tex_issue = state == SQ_TEX;
  assign alu_issue = state == SQ_ALU;
  assign busy      = state != SQ_IDLE;
  assign done      = done_q;
  assign desc_err  = err_q;
endmodule

// File: rtl/seq_checker.sv
module seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tex_issue,
  input logic [4:0] tex_addr,
  input logic       tex_ready,
  input logic       alu_issue,
  input logic [5:0] alu_addr,
  input logic       alu_ready,
  input logic       busy,
  input logic       done,
  input logic       desc_err
);
  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(tex_issue && alu_issue)); // R3
  AST_TEX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tex_issue && !tex_ready) |=> (tex_issue && $stable(tex_addr))); // R7
  AST_ALU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_issue && !alu_ready) |=> (alu_issue && $stable(alu_addr))); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(alu_issue && alu_ready) && !busy)); // R8
  AST_ERR_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |-> (!busy && !tex_issue && !alu_issue)); // R10
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    desc_err |=> !desc_err); // R10
endmodule

bind shader_node_seq seq_checker u_seq_chk (
  .clk(clk), .rst_n(rst_n),
  .tex_issue(tex_issue), .tex_addr(tex_addr), .tex_ready(tex_ready),
  .alu_issue(alu_issue), .alu_addr(alu_addr), .alu_ready(alu_ready),
  .busy(busy), .done(done), .desc_err(desc_err)
);

// File: tb/test_shader_node_seq.sv
`timescale 1ns/1ps
module test_shader_node_seq;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       node_last = '0;
  logic             first_tex_en = 1'b0;
  logic [5:0]       alu_base = '0;
  logic [4:0]       tex_base = '0;
  logic [3:0][22:0] node_desc = '0;
  logic             tex_ready = 1'b1, alu_ready = 1'b1;
  logic             tex_issue, alu_issue, busy, done, desc_err;
  logic [4:0]       tex_addr;
  logic [5:0]       alu_addr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  shader_node_seq i_shader_node_seq (.*);

  // reference model state
  int  q_str[$];   // 0 = texture, 1 = arithmetic
  int  q_adr[$];
  bit  go = 0, rnd = 0;
  bit  done_cur = 0, done_nxt = 0, err_cur = 0, err_nxt = 0;

  function automatic logic [22:0] mk(int ao, int ae, int to, int te, bit fin);
    return {fin, 5'(te), 5'(to), 6'(ae), 6'(ao)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic build();
    int n = int'(node_last) + 1;
    for (int s = 4 - n; s < 4; s++) begin
      int ao = node_desc[s][5:0];
      int ae = node_desc[s][11:6];
      int to = node_desc[s][16:12];
      int te = node_desc[s][21:17];
      if (s != 4 - n || first_tex_en)
        for (int i = 0; i <= te; i++) begin
          q_str.push_back(0); q_adr.push_back((int'(tex_base) + to + i) % 32);
        end
      for (int i = 0; i <= ae; i++) begin
        q_str.push_back(1); q_adr.push_back((int'(alu_base) + ao + i) % 64);
      end
    end
  endtask

  task automatic tick();
    bit exp_t, exp_a, was_busy, bad;
    @(negedge clk);
    exp_t = q_str.size() > 0 && q_str[0] == 0;
    exp_a = q_str.size() > 0 && q_str[0] == 1;
    chk(tex_issue === exp_t, "R1 R3 R4 R6 tex_issue", tex_issue, exp_t);
    if (exp_t) chk(tex_addr === 5'(q_adr[0]), "R2 R5 R7 tex_addr", tex_addr, q_adr[0]);
    chk(alu_issue === exp_a, "R1 R3 R4 R6 alu_issue", alu_issue, exp_a);
    if (exp_a) chk(alu_addr === 6'(q_adr[0]), "R2 R5 R7 alu_addr", alu_addr, q_adr[0]);
    chk(busy === (q_str.size() > 0), "R8 R9 busy", busy, q_str.size() > 0);
    chk(done === done_cur, "R8 done", done, done_cur);
    chk(desc_err === err_cur, "R10 desc_err", desc_err, err_cur);
    tex_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
    alu_ready = rnd ? ($urandom % 3 != 0) : 1'b1;
    was_busy = q_str.size() > 0;
    if (was_busy && ((q_str[0] == 0 && tex_ready) || (q_str[0] == 1 && alu_ready))) begin
      void'(q_str.pop_front()); void'(q_adr.pop_front());
      if (q_str.size() == 0) done_nxt = 1;
    end
    start = 1'b0;
    if (go) begin
      go = 0;
      start = 1'b1;
      if (!was_busy) begin
        bad = !node_desc[3][22] || node_desc[0][22] || node_desc[1][22] || node_desc[2][22];
        if (bad) err_nxt = 1; else build();
      end
    end
    done_cur = done_nxt; done_nxt = 0;
    err_cur = err_nxt; err_nxt = 0;
  endtask

  task automatic run(int stray_at);
    int k = 0;
    go = 1;
    tick();
    while (q_str.size() > 0 && k < 5000) begin
      if (k == stray_at) go = 1;   // R9: restart attempt mid-run
      tick();
      k++;
    end
    if (k >= 5000) chk(0, "watchdog", k, 0);
    repeat (3) tick();
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({tex_issue, alu_issue, busy, done, desc_err} === 5'b0, "R11 reset outputs",
        {tex_issue, alu_issue, busy, done, desc_err}, 0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R1 R4: one node, no texture phase
    node_last = 0; first_tex_en = 0; alu_base = 5; tex_base = 0;
    node_desc = '0; node_desc[3] = mk(3, 2, 7, 4, 1);
    run(-1);

    // R5: four nodes, offsets wrap both stores
    node_last = 3; first_tex_en = 1; alu_base = 60; tex_base = 30;
    node_desc[0] = mk(2, 1, 1, 0, 0);
    node_desc[1] = mk(10, 0, 3, 2, 0);
    node_desc[2] = mk(63, 3, 31, 1, 0);
    node_desc[3] = mk(0, 5, 0, 4, 1);
    run(-1);

    // R7 R9: two nodes, random stalls, stray start
    rnd = 1;
    node_last = 1; first_tex_en = 1; alu_base = 12; tex_base = 4;
    node_desc[0] = mk(9, 9, 9, 9, 0);
    node_desc[1] = mk(9, 9, 9, 9, 0);
    node_desc[2] = mk(1, 4, 2, 3, 0);
    node_desc[3] = mk(20, 2, 8, 0, 1);
    run(4);

    // R4: two nodes, first texture phase skipped, later node keeps it
    node_last = 1; first_tex_en = 0;
    run(2);

    // R1: three nodes under stalls
    node_last = 2; first_tex_en = 1;
    node_desc[1] = mk(40, 6, 16, 5, 0);
    run(7);
    rnd = 0;

    // R10: final flag missing
    node_desc[3] = mk(0, 1, 0, 1, 0);
    run(-1);
    // R10: flag on early slot
    node_desc[3] = mk(0, 1, 0, 1, 1);
    node_desc[1] = mk(0, 1, 0, 1, 1);
    run(-1);
    // recovery after error
    node_desc[1] = mk(0, 1, 0, 1, 0);
    node_last = 0; first_tex_en = 1;
    run(-1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule